// File: doc/BRIEF.md
# Delay Line Initialization Sequencer

This block puts a bank of programmable delay lines into a known starting state before a timing calibration begins. A start request, from either a local push button or a host command, launches one fixed write sequence over a single shared 10-bit code bus. Each delay line has its own load-enable line, and only the selected device takes in the code on the bus.

The search delay lines are written first, one at a time in index order, each with the minimum delay code. The pulse-stretcher line comes next and gets the code for a 35 ns pulse. The monostable line comes last and gets the code for a 3 ns pulse. Every device owns a time slot of `SLOT_CYC` cycles. The enable and the code are held for the first `HOLD_CYC` cycles of the slot, and the bus is quiet for the rest of it. When the last slot ends, an init-done flag goes high, and the coarse search logic downstream may then start.

Top module: `dlinit_seq`

## Requirements
- R1: While reset is asserted, and while idle after reset, all enables are low, the bus reads 0 and init_done is low.
- R2: When either start input (or both) is high at a clock edge in the idle or done state, the first load slot begins at that edge.
- R3: Search delay lines 0 to NUM_SEARCH-1 are loaded first, in ascending order, each with MIN_CODE (default 0x000). Enable bit i selects search line i.
- R4: After the search lines, the stretcher line (enable bit NUM_SEARCH) is loaded with STRETCH_CODE (default 0x023).
- R5: The monostable line (enable bit NUM_SEARCH+1) is loaded last, with MONO_CODE (default 0x003).
- R6: Each device's enable stays high for exactly HOLD_CYC (3) consecutive cycles at the start of its SLOT_CYC (9) cycle slot. For the rest of the slot all enables are low and the bus reads 0.
- R7: At most one enable is high in any cycle, and the bus then carries that device's code.
- R8: init_done goes high NUM_DEV*SLOT_CYC cycles after the start edge, with no enable active, and stays high until the next start or reset.
- R9: Start inputs are ignored while a sequence is running, so its timing is unchanged.
- R10: A start while init_done is high drops init_done and runs the whole sequence again.
- R11: A reset in the middle of a sequence returns the block to idle with all enables low, and it stays idle until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_btn | input | 1 | Local push-button start request |
| start_host | input | 1 | Host start command |
| dl_en | output | NUM_SEARCH+2 | Per-device load enables: search lines, then stretcher, then monostable |
| dl_bus | output | BUS_W | Shared delay-code bus |
| init_done | output | 1 | Initialization finished, coarse search may begin |

## Verification
A corrupted slot counter or device index shows up at the ports within one cycle. Either an enable stretches past three cycles, or a device gets skipped or repeated, or the bus carries another device's code. A sequencer state that absorbs a start in mid-run shows up as a shifted enable pattern at the very next cycle. A missed or early completion shows up as an init_done edge off by at least one cycle, compared against a per-cycle expected trace.

// File: rtl/dlinit_pkg.sv
package dlinit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dlinit_rst_sync.sv
module dlinit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/dlinit_slot_timer.sv
module dlinit_slot_timer #(
  parameter int NUM_DEV  = 5,
  parameter int HOLD_CYC = 3,
  parameter int SLOT_CYC = 9,
  localparam int CNT_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [DEV_W-1:0] dev_q,
  output logic             in_hold,
  output logic             seq_last
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_HOLD = CNT_W'(HOLD_CYC);
  localparam logic [DEV_W-1:0] DEV_LAST = DEV_W'(NUM_DEV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEV_W-1:0] dev_d;

  always_comb begin
    cnt_d = cnt_q;
    dev_d = dev_q;
    if (!run) begin
      cnt_d = '0;
      dev_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
      dev_d = (dev_q == DEV_LAST) ? '0 : dev_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dev_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      dev_q <= dev_d;
    end
  end

  assign in_hold  = run && (cnt_q < CNT_HOLD);
  assign seq_last = run && (cnt_q == CNT_LAST) && (dev_q == DEV_LAST);

  // R6: slot counter never leaves its range
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  // R6: inside a slot the counter advances by one each cycle
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != CNT_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: device index advances in ascending order at slot ends
  a_r3_dev_order: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q == CNT_LAST && dev_q != DEV_LAST) |=> (dev_q == $past(dev_q) + 1'b1));
endmodule

// File: rtl/dlinit_bus_drive.sv
module dlinit_bus_drive #(
  parameter int NUM_SEARCH = 3,
  parameter int BUS_W      = 10,
  parameter logic [BUS_W-1:0] MIN_CODE     = '0,
  parameter logic [BUS_W-1:0] STRETCH_CODE = BUS_W'(35),
  parameter logic [BUS_W-1:0] MONO_CODE    = BUS_W'(3),
  localparam int NUM_DEV = NUM_SEARCH + 2,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [DEV_W-1:0]   dev,
  output logic [NUM_DEV-1:0] dl_en,
  output logic [BUS_W-1:0]   dl_bus
);
  logic [BUS_W-1:0] code_tab [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_code
    if (g < NUM_SEARCH) begin : g_search
      assign code_tab[g] = MIN_CODE;
    end else if (g == NUM_SEARCH) begin : g_stretch
      assign code_tab[g] = STRETCH_CODE;
    end else begin : g_mono
      assign code_tab[g] = MONO_CODE;
    end
  end

  always_comb begin
    dl_en  = '0;
    dl_bus = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (active && (dev == DEV_W'(i))) begin
        dl_en[i] = 1'b1;
        dl_bus   = dl_bus | code_tab[i];
      end
    end
  end

  // R7: never two devices enabled at once
  a_r7_single_en: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dl_en));
  // R6: bus is quiet whenever no device is enabled
  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_en == '0) |-> (dl_bus == '0));
  // R4: stretcher enable carries the stretcher code
  a_r4_stretch_code: assert property (@(posedge clk) disable iff (!rst_n)
    dl_en[NUM_SEARCH] |-> (dl_bus == STRETCH_CODE));
  // R5: monostable enable carries the monostable code
  a_r5_mono_code: assert property (@(posedge clk) disable iff (!rst_n)
    dl_en[NUM_SEARCH+1] |-> (dl_bus == MONO_CODE));
endmodule

// File: rtl/dlinit_seq.sv
module dlinit_seq
  import dlinit_pkg::*;
#(
  parameter int NUM_SEARCH = 3,
  parameter int BUS_W      = 10,
  parameter int HOLD_CYC   = 3,
  parameter int SLOT_CYC   = 9,
  parameter logic [BUS_W-1:0] MIN_CODE     = '0,
  parameter logic [BUS_W-1:0] STRETCH_CODE = BUS_W'(35),
  parameter logic [BUS_W-1:0] MONO_CODE    = BUS_W'(3),
  localparam int NUM_DEV = NUM_SEARCH + 2,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_btn,
  input  logic               start_host,
  output logic [NUM_DEV-1:0] dl_en,
  output logic [BUS_W-1:0]   dl_bus,
  output logic               init_done
);
  seq_state_e       state_q, state_d;
  logic             rst_i_n;
  logic             start_any;
  logic             run;
  logic             in_hold;
  logic             seq_last;
  logic [DEV_W-1:0] dev;

  dlinit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign start_any = start_btn | start_host;
  assign run       = (state_q == ST_LOAD);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_any) state_d = ST_LOAD;
      ST_LOAD: if (seq_last)  state_d = ST_DONE;
      ST_DONE: if (start_any) state_d = ST_LOAD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  dlinit_slot_timer #(
    .NUM_DEV  (NUM_DEV),
    .HOLD_CYC (HOLD_CYC),
    .SLOT_CYC (SLOT_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .run      (run),
    .dev_q    (dev),
    .in_hold  (in_hold),
    .seq_last (seq_last)
  );

  dlinit_bus_drive #(
    .NUM_SEARCH   (NUM_SEARCH),
    .BUS_W        (BUS_W),
    .MIN_CODE     (MIN_CODE),
    .STRETCH_CODE (STRETCH_CODE),
    .MONO_CODE    (MONO_CODE)
  ) u_drive (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .active (in_hold),
    .dev    (dev),
    .dl_en  (dl_en),
    .dl_bus (dl_bus)
  );

  assign init_done = (state_q == ST_DONE);

  // R2: a start outside a running sequence launches loading
  a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q != ST_LOAD && start_any) |=> (state_q == ST_LOAD));
  // R9: a running sequence is not disturbed until its last cycle
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_i_n)
    (run && !seq_last) |=> (run && !init_done));
  // R8: completion flag never overlaps an active enable
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    init_done |-> (dl_en == '0));
  // R8: completion only follows the final slot
  a_r8_done_after_load: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(init_done) |-> ($past(seq_last)));
endmodule

// File: tb/dlinit_seq_tb.sv
module dlinit_seq_tb_top;
  localparam int NS    = 3;
  localparam int ND    = NS + 2;
  localparam int HOLD  = 3;
  localparam int SLOT  = 9;
  localparam int TOTAL = ND * SLOT;

  typedef struct {
    logic [ND-1:0] en;
    logic [9:0]    bus;
    logic          done;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_btn;
  logic          start_host;
  logic [ND-1:0] dl_en;
  logic [9:0]    dl_bus;
  logic          init_done;

  int   checks   = 0;
  int   failures = 0;
  exp_t q[$];

  // bench-side model
  bit   m_busy = 0;
  bit   m_done = 0;
  int   m_k    = 0;

  always #5 clk = ~clk;

  dlinit_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_btn  (start_btn),
    .start_host (start_host),
    .dl_en      (dl_en),
    .dl_bus     (dl_bus),
    .init_done  (init_done)
  );

  function automatic logic [9:0] code_of(int idx);
    if (idx < NS)       return 10'h000;
    else if (idx == NS) return 10'h023;
    else                return 10'h003;
  endfunction

  task automatic step(input logic b, input logic h, input logic r, input string tag);
    exp_t e;
    @(negedge clk);
    start_btn  = b;
    start_host = h;
    rst_n      = r;
    if (!r) begin
      m_busy = 0; m_done = 0; m_k = 0;
    end else if (m_busy) begin
      m_k++;
      if (m_k == TOTAL) begin m_busy = 0; m_done = 1; end
    end else if (b || h) begin
      m_busy = 1; m_k = 0; m_done = 0;
    end
    e.en = '0; e.bus = '0; e.done = m_done; e.tag = tag;
    if (m_busy) begin
      if ((m_k % SLOT) < HOLD) begin
        e.en  = ND'(1) << (m_k / SLOT);
        e.bus = code_of(m_k / SLOT);
      end
      if (tag == "") begin
        if (e.en == '0)               e.tag = "R6";
        else if ((m_k / SLOT) < NS)   e.tag = "R3";
        else if ((m_k / SLOT) == NS)  e.tag = "R4";
        else                          e.tag = "R5";
      end
    end else if (tag == "") begin
      e.tag = m_done ? "R8" : "R1";
    end
    q.push_back(e);
  endtask

  task automatic run_idle(int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, tag);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (dl_en !== e.en || dl_bus !== e.bus || init_done !== e.done) begin
          failures++;
          $display("FAIL %s en=%b bus=%h done=%b expected en=%b bus=%h done=%b at %0t",
                   e.tag, dl_en, dl_bus, init_done, e.en, e.bus, e.done, $time);
        end
        checks++;
        if ($countones(dl_en) > 1) begin
          failures++;
          $display("FAIL R7 en=%b expected at most one bit set", dl_en);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_btn = 1'b0; start_host = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R1");
    run_idle(4, "R1");
    // R2: button start, full sequence R3 R4 R5 R6, then R8
    step(1'b1, 1'b0, 1'b1, "R2");
    run_idle(TOTAL + 3, "");
    // R8: done stays high
    run_idle(5, "R8");
    // R10: host start from done, R9: starts mid-run ignored
    step(1'b0, 1'b1, 1'b1, "R10");
    for (int i = 1; i <= TOTAL + 2; i++) begin
      if (i == 4 || i == 10 || i == 30 || i == TOTAL - 1)
        step(1'b1, 1'b1, 1'b1, "R9");
      else
        step(1'b0, 1'b0, 1'b1, "");
    end
    // R11: reset in mid-sequence
    step(1'b1, 1'b0, 1'b1, "R10");
    run_idle(20, "");
    step(1'b0, 1'b0, 1'b0, "R11");
    step(1'b0, 1'b0, 1'b0, "R11");
    run_idle(5, "R11");
    // R2: both starts together
    step(1'b1, 1'b1, 1'b1, "R2");
    run_idle(TOTAL + 2, "");
    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule